// File: doc/BRIEF.md
# Keyboard Scancode Control-Line Decoder

This block sits between a keyboard byte source and a handful of device control inputs. It takes one scancode byte per cycle on a valid/data interface and turns selected keys into control signals. These are a power-button level, three latched switch states (slider, camera cover, headphone presence) and three momentary active-low button lines (keyboard lock, camera focus, camera shutter). It also emits step commands for an accelerometer model. A step command carries an axis index, a direction and an active flag.

An extended-code prefix byte marks the next byte as part of the upper half of the code space, and bit 7 of every non-prefix byte marks a key release. None of the mapped keys lives in the extended half, so an extended key never disturbs a control line. Codes with no mapping are ignored. Every result is registered: the outputs reflect a byte at the clock edge that samples it.

Top module: `scd_top`

## Requirements
- R1: While no prefix is pending, the byte 0xE0 arms a prefix flag and produces no key event. The next valid byte forms the code {1, byte[6:0]} and clears the flag. A second 0xE0 while the flag is armed is therefore consumed as extended code 0xE0 (released), not as a new prefix. Extended codes drive no output.
- R2: For every non-prefix byte, bit 7 set means release and bit 7 clear means press. Bits 6:0 select the key.
- R3: Code 0x01 drives `pwr_btn` high from its press and low from its release.
- R4: A press of code 0x3B inverts `slide_open`, and a press of code 0x3D inverts `cover_open`. Releases of these codes leave both outputs unchanged.
- R5: A press of code 0x40 inverts an internal headphone-connected state, and `hp_line` carries the inverse of that state. A release has no effect.
- R6: Codes 0x3C, 0x3E and 0x3F drive `lock_n`, `focus_n` and `shutter_n` low from their press and high from their release.
- R7: Codes 0x4F/0x50, 0x4B/0x4C and 0x47/0x48 issue step commands for axes 0, 1 and 2. The lower code of each pair is decrease (`step_up`=0) and the higher is increase (`step_up`=1). Each command is a single-cycle `step_valid` pulse, with `step_active`=1 for a press and 0 for a release.
- R8: After reset, `pwr_btn`, `slide_open`, `cover_open` and `step_valid` are 0, and `hp_line`, `lock_n`, `focus_n` and `shutter_n` are 1. No prefix is pending.
- R9: A byte whose code is not mapped, or a cycle with `code_valid` low, changes no output, and `step_valid` stays 0.
- R10: An output change caused by a byte is visible right after the rising edge that samples that byte, and `step_valid` drops after the following edge unless another step code arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | A scancode byte is present this cycle |
| code_byte | input | 8 | Scancode byte |
| pwr_btn | output | 1 | Power button level, high while held |
| slide_open | output | 1 | Slider switch state |
| cover_open | output | 1 | Camera cover state |
| hp_line | output | 1 | Inverse of headphone-connected state |
| lock_n | output | 1 | Keyboard lock button, active low |
| focus_n | output | 1 | Camera focus button, active low |
| shutter_n | output | 1 | Camera shutter button, active low |
| step_valid | output | 1 | Single-cycle step command strobe |
| step_axis | output | 2 | Axis index of the step command |
| step_up | output | 1 | Step direction, 1 = increase |
| step_active | output | 1 | 1 = key pressed, 0 = key released |

## Verification
Every result of this block is due one edge after the byte: the line outputs and the step strobe take their new value at the rising edge that samples `code_valid`. The strobe falls again at the next edge. The bench therefore drives each byte at a falling edge, holds it for exactly one rising edge, and compares all outputs at the following falling edge against a bench model. That model was advanced by the same byte. Idle cycles between bytes are checked the same way, to confirm that the strobe has fallen and nothing else moved.

// File: rtl/scd_pkg.sv
package scd_pkg;

   localparam int CODE_W = 8;

   typedef enum logic {
      LM_LEVEL  = 1'b0,
      LM_TOGGLE = 1'b1
   } line_mode_e;

   typedef struct packed {
      logic [CODE_W-1:0] key;
      line_mode_e        mode;
      logic              inv;
   } line_cfg_t;

   typedef struct packed {
      logic              valid;
      logic [CODE_W-1:0] code;
      logic              rel;
   } key_ev_t;

   localparam int NUM_LINES = 7;

   // index: 0 power, 1 slider, 2 cover, 3 headphone, 4 lock, 5 focus, 6 shutter
   localparam line_cfg_t LINE_CFG [NUM_LINES] = '{
      '{key: 8'h01, mode: LM_LEVEL,  inv: 1'b0},
      '{key: 8'h3B, mode: LM_TOGGLE, inv: 1'b0},
      '{key: 8'h3D, mode: LM_TOGGLE, inv: 1'b0},
      '{key: 8'h40, mode: LM_TOGGLE, inv: 1'b1},
      '{key: 8'h3C, mode: LM_LEVEL,  inv: 1'b1},
      '{key: 8'h3E, mode: LM_LEVEL,  inv: 1'b1},
      '{key: 8'h3F, mode: LM_LEVEL,  inv: 1'b1}
   };

endpackage

// File: rtl/scd_prefix.sv
module scd_prefix
   import scd_pkg::*;
#(
   parameter logic [CODE_W-1:0] PREFIX = 8'hE0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_byte,
   output key_ev_t           ev
);

   generate
      if (PREFIX[CODE_W-1] == 1'b0) begin : g_bad_prefix
         $error("scd_prefix: prefix byte must have its top bit set");
      end
   endgenerate

   logic ext_q;
   logic is_pfx;

   assign is_pfx = in_valid && !ext_q && (in_byte == PREFIX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= 1'b0;
      end else if (in_valid) begin
         ext_q <= is_pfx;
      end
   end

   always_comb begin
      ev.valid = in_valid && !is_pfx;
      ev.code  = {ext_q, in_byte[CODE_W-2:0]};
      ev.rel   = in_byte[CODE_W-1];
   end

   // R1: the armed flag lasts for exactly one following byte
   a_r1_prefix_consumed : assert property (@(posedge clk) disable iff (!rst_n)
      (ext_q && in_valid) |=> !ext_q);

   // R1: a byte arriving with the flag armed yields an extended key event
   a_r1_ext_event : assert property (@(posedge clk) disable iff (!rst_n)
      (ext_q && in_valid) |-> (ev.valid && ev.code[CODE_W-1]));

endmodule

// File: rtl/scd_line.sv
module scd_line
   import scd_pkg::*;
#(
   parameter logic [CODE_W-1:0] KEY  = 8'h01,
   parameter line_mode_e        MODE = LM_LEVEL,
   parameter logic              INV  = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  key_ev_t ev,
   output logic    line
);

   generate
      if (KEY[CODE_W-1] != 1'b0) begin : g_bad_key
         $error("scd_line: mapped key must lie in the plain code half");
      end
   endgenerate

   logic hit;
   logic state_q;

   assign hit = ev.valid && (ev.code == KEY);

   generate
      if (MODE == LM_TOGGLE) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state_q <= 1'b0;
            end else if (hit && !ev.rel) begin
               state_q <= !state_q;
            end
         end

         // R4 R5: only a press of the own key may move the state
         a_r4_toggle_press_only : assert property (@(posedge clk) disable iff (!rst_n)
            !(hit && !ev.rel) |=> $stable(state_q));

         a_r5_toggle_flips : assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !ev.rel) |=> (state_q != $past(state_q)));
      end else begin : g_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state_q <= 1'b0;
            end else if (hit) begin
               state_q <= !ev.rel;
            end
         end

         // R3 R6: the held level follows the last press or release
         a_r6_level_follows : assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (line == ($past(ev.rel) ^ !INV)));

         a_r9_level_idle : assert property (@(posedge clk) disable iff (!rst_n)
            !hit |=> $stable(line));
      end
   endgenerate

   assign line = state_q ^ INV;

endmodule

// File: rtl/scd_stepper.sv
module scd_stepper
   import scd_pkg::*;
#(
   parameter int                       N_AXES    = 3,
   parameter logic [N_AXES*CODE_W-1:0] DOWN_KEYS = {8'h47, 8'h4B, 8'h4F},
   localparam int                      AXIS_W    = (N_AXES > 1) ? $clog2(N_AXES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  key_ev_t           ev,
   output logic              step_valid,
   output logic [AXIS_W-1:0] step_axis,
   output logic              step_up,
   output logic              step_active
);

   generate
      if (N_AXES < 1) begin : g_bad_axes
         $error("scd_stepper: at least one axis is required");
      end
   endgenerate

   logic [N_AXES-1:0] hit_dn;
   logic [N_AXES-1:0] hit_up;

   genvar ga;
   generate
      for (ga = 0; ga < N_AXES; ga++) begin : g_axis
         localparam logic [CODE_W-1:0] DN = DOWN_KEYS[ga*CODE_W +: CODE_W];
         localparam logic [CODE_W-1:0] UP = DN + 8'd1;
         if (DN >= 8'h7F) begin : g_bad_axis_key
            $error("scd_stepper: axis key pair must lie in the plain code half");
         end
         assign hit_dn[ga] = ev.valid && (ev.code == DN);
         assign hit_up[ga] = ev.valid && (ev.code == UP);
      end
   endgenerate

   logic              any_hit;
   logic [AXIS_W-1:0] sel_axis;
   logic              sel_up;

   always_comb begin
      sel_axis = '0;
      sel_up   = 1'b0;
      for (int a = 0; a < N_AXES; a++) begin
         if (hit_dn[a] || hit_up[a]) begin
            sel_axis = AXIS_W'(a);
            sel_up   = hit_up[a];
         end
      end
   end

   assign any_hit = |{hit_dn, hit_up};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_valid  <= 1'b0;
         step_axis   <= '0;
         step_up     <= 1'b0;
         step_active <= 1'b0;
      end else begin
         step_valid <= any_hit;
         if (any_hit) begin
            step_axis   <= sel_axis;
            step_up     <= sel_up;
            step_active <= !ev.rel;
         end
      end
   end

   // R7 R10: a strobe exists only for an axis key seen one edge before
   a_r7_strobe_source : assert property (@(posedge clk) disable iff (!rst_n)
      !any_hit |=> !step_valid);

   a_r7_active_matches : assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |=> (step_valid && (step_active == !$past(ev.rel))));

   a_r7_single_key : assert property (@(posedge clk) disable iff (!rst_n)
      $countones({hit_dn, hit_up}) <= 1);

endmodule

// File: rtl/scd_top.sv
module scd_top
   import scd_pkg::*;
#(
   parameter logic [CODE_W-1:0] PREFIX_CODE = 8'hE0,
   parameter int                N_AXES      = 3,
   parameter logic [N_AXES*CODE_W-1:0] AXIS_DOWN_KEYS = {8'h47, 8'h4B, 8'h4F},
   localparam int               AXIS_W      = (N_AXES > 1) ? $clog2(N_AXES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              code_valid,
   input  logic [7:0]        code_byte,
   output logic              pwr_btn,
   output logic              slide_open,
   output logic              cover_open,
   output logic              hp_line,
   output logic              lock_n,
   output logic              focus_n,
   output logic              shutter_n,
   output logic              step_valid,
   output logic [AXIS_W-1:0] step_axis,
   output logic              step_up,
   output logic              step_active
);

   key_ev_t              ev;
   logic [NUM_LINES-1:0] lines;

   scd_prefix #(.PREFIX(PREFIX_CODE)) u_prefix (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (code_valid),
      .in_byte  (code_byte),
      .ev       (ev)
   );

   genvar gl;
   generate
      for (gl = 0; gl < NUM_LINES; gl++) begin : g_line
         scd_line #(
            .KEY  (LINE_CFG[gl].key),
            .MODE (LINE_CFG[gl].mode),
            .INV  (LINE_CFG[gl].inv)
         ) u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev),
            .line  (lines[gl])
         );
      end
   endgenerate

   assign pwr_btn    = lines[0];
   assign slide_open = lines[1];
   assign cover_open = lines[2];
   assign hp_line    = lines[3];
   assign lock_n     = lines[4];
   assign focus_n    = lines[5];
   assign shutter_n  = lines[6];

   scd_stepper #(
      .N_AXES    (N_AXES),
      .DOWN_KEYS (AXIS_DOWN_KEYS)
   ) u_stepper (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev          (ev),
      .step_valid  (step_valid),
      .step_axis   (step_axis),
      .step_up     (step_up),
      .step_active (step_active)
   );

   // R1: a byte taken as prefix leaves every output untouched
   a_r1_prefix_silent : assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && !ev.valid) |=> ($stable(lines) && !step_valid));

   // R9: idle cycles move no line
   a_r9_idle_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !code_valid |=> ($stable(lines) && !step_valid));

endmodule

// File: tb/scd_top_test.sv
module scd_top_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       code_valid = 1'b0;
   logic [7:0] code_byte = 8'h00;
   logic       pwr_btn, slide_open, cover_open, hp_line;
   logic       lock_n, focus_n, shutter_n;
   logic       step_valid, step_up, step_active;
   logic [1:0] step_axis;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   scd_top uut (
      .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_byte(code_byte),
      .pwr_btn(pwr_btn), .slide_open(slide_open), .cover_open(cover_open),
      .hp_line(hp_line), .lock_n(lock_n), .focus_n(focus_n), .shutter_n(shutter_n),
      .step_valid(step_valid), .step_axis(step_axis), .step_up(step_up),
      .step_active(step_active)
   );

   // bench model
   bit m_ext, m_hp;
   bit e_pwr, e_slide, e_cover, e_hp, e_lock, e_focus, e_shut;
   bit e_sv, e_up, e_act;
   logic [1:0] e_axis;

   task automatic model_reset();
      m_ext = 0; m_hp = 0;
      e_pwr = 0; e_slide = 0; e_cover = 0; e_hp = 1;
      e_lock = 1; e_focus = 1; e_shut = 1;
      e_sv = 0; e_up = 0; e_act = 0; e_axis = 2'd0;
   endtask

   function automatic bit is_axis(input logic [7:0] c, output logic [1:0] ax, output bit up);
      ax = 2'd0; up = 0;
      case (c)
         8'h4F: begin ax = 2'd0; up = 0; return 1; end
         8'h50: begin ax = 2'd0; up = 1; return 1; end
         8'h4B: begin ax = 2'd1; up = 0; return 1; end
         8'h4C: begin ax = 2'd1; up = 1; return 1; end
         8'h47: begin ax = 2'd2; up = 0; return 1; end
         8'h48: begin ax = 2'd2; up = 1; return 1; end
         default: return 0;
      endcase
   endfunction

   task automatic model_byte(input logic [7:0] b);
      logic [7:0] c;
      bit rel, up;
      logic [1:0] ax;
      e_sv = 0;
      if (!m_ext && b == 8'hE0) begin
         m_ext = 1;
         return;
      end
      c = {m_ext, b[6:0]};
      rel = b[7];
      m_ext = 0;
      case (c)
         8'h01: e_pwr = !rel;
         8'h3B: if (!rel) e_slide = !e_slide;
         8'h3D: if (!rel) e_cover = !e_cover;
         8'h40: if (!rel) m_hp = !m_hp;
         8'h3C: e_lock = rel;
         8'h3E: e_focus = rel;
         8'h3F: e_shut = rel;
         default: ;
      endcase
      e_hp = !m_hp;
      if (is_axis(c, ax, up)) begin
         e_sv = 1; e_axis = ax; e_up = up; e_act = !rel;
      end
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string ctx);
      chk({ctx, " R3 pwr_btn"},    {7'd0, pwr_btn},    {7'd0, e_pwr});
      chk({ctx, " R4 slide_open"}, {7'd0, slide_open}, {7'd0, e_slide});
      chk({ctx, " R4 cover_open"}, {7'd0, cover_open}, {7'd0, e_cover});
      chk({ctx, " R5 hp_line"},    {7'd0, hp_line},    {7'd0, e_hp});
      chk({ctx, " R6 lock_n"},     {7'd0, lock_n},     {7'd0, e_lock});
      chk({ctx, " R6 focus_n"},    {7'd0, focus_n},    {7'd0, e_focus});
      chk({ctx, " R6 shutter_n"},  {7'd0, shutter_n},  {7'd0, e_shut});
      chk({ctx, " R10 step_valid"}, {7'd0, step_valid}, {7'd0, e_sv});
      if (e_sv) begin
         chk({ctx, " R7 step_axis"},   {6'd0, step_axis},   {6'd0, e_axis});
         chk({ctx, " R7 step_up"},     {7'd0, step_up},     {7'd0, e_up});
         chk({ctx, " R7 step_active"}, {7'd0, step_active}, {7'd0, e_act});
      end
   endtask

   // drive one byte for one rising edge, check at the next falling edge
   task automatic send(input logic [7:0] b, input string ctx);
      @(negedge clk);
      code_valid = 1'b1;
      code_byte  = b;
      model_byte(b);
      @(negedge clk);
      code_valid = 1'b0;
      code_byte  = $urandom_range(0, 255);
      check_all(ctx);
   endtask

   task automatic idle(input string ctx);
      @(negedge clk);
      e_sv = 0;
      check_all(ctx);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] pool [16];
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      check_all("R8 reset");
      rst_n = 1'b1;
      idle("R8 after reset");

      send(8'h01, "R3 press");
      send(8'h81, "R3 release R2");
      send(8'hE0, "R1 prefix arm");
      send(8'h01, "R1 extended ignored");
      send(8'hE0, "R1 arm again");
      send(8'hE0, "R1 second prefix is a code");
      send(8'h01, "R1 flag cleared");
      send(8'h81, "R2 release");
      send(8'h3B, "R4 slider press");
      send(8'hBB, "R4 slider release ignored");
      send(8'h3D, "R4 cover press");
      send(8'h40, "R5 headphone press");
      send(8'hC0, "R5 headphone release ignored");
      send(8'h3C, "R6 lock press");
      send(8'hBC, "R6 lock release");
      send(8'h50, "R7 axis0 up press");
      idle("R10 strobe drops");
      send(8'h47, "R7 axis2 down press");
      send(8'h4C, "R7 back-to-back axis1 up");
      send(8'hC8, "R7 axis2 up release");
      send(8'h7F, "R9 unmapped");
      send(8'hE0, "R1 arm before axis");
      send(8'h4F, "R1 extended axis ignored");
      idle("R9 idle");

      pool = '{8'h01, 8'h3B, 8'h3C, 8'h3D, 8'h3E, 8'h3F, 8'h40, 8'h47,
               8'h48, 8'h4B, 8'h4C, 8'h4F, 8'h50, 8'hE0, 8'h11, 8'h2A};
      for (int i = 0; i < 1500; i++) begin
         logic [7:0] b;
         int sel;
         sel = $urandom_range(0, 19);
         if (sel < 16) begin
            b = pool[sel];
            if (b != 8'hE0 && $urandom_range(0, 1) == 1) b = b | 8'h80;
         end else begin
            b = 8'($urandom_range(0, 255));
         end
         send(b, "random R2 R9");
         if ($urandom_range(0, 3) == 0) idle("random R10 idle");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule